// File: doc/BRIEF.md
# Deep-Sleep Power Sequencer

This block steps a chip between its awake mode and a deep-sleep mode. The clock controller raises an idle request once the processor domains have stopped. The block then gates the core input clock and raises a wake-up handshake toward the clock controller. One cycle later it enters deep sleep. There it asks the external supply regulator for its reduced voltage level, and it can also stop the crystal oscillator.

An asynchronous wake-up request from the interrupt logic ends deep sleep. So does a synchronous clock request. The wake-up request is first resynchronised on the always-on clock. On exit the block drops the low-voltage request at once and releases the oscillator. It then waits out a settling time before it turns the core clock back on. The settling time is the regulator delay, or the larger of the regulator and oscillator delays when the oscillator was stopped. Software sets both delays, and the oscillator-stop option, through a simple write port before it requests sleep.

Top module: `dsleep_seq`

## Requirements
- R1: After reset, core_clk_en is 1 and low_volt, osc_stop and wake_hs are 0. Both delay registers hold their all-ones value (4095 with the default 12-bit width). The oscillator-stop option is off.
- R2: An idle request seen at a clock edge in the awake mode makes core_clk_en 0 and wake_hs 1 from that edge on. low_volt stays 0 for that first gated cycle.
- R3: When no wake condition is present during the gated cycle, low_volt becomes 1 at the next edge and the block is in deep sleep.
- R4: In deep sleep, osc_stop is 1 exactly when bit 9 of the last word written to the control address (2) was 1. Outside deep sleep, osc_stop is 0.
- R5: In deep sleep, a clock request drops low_volt and osc_stop at the next edge. A rise of the asynchronous wake input drops them at the third edge after the rise.
- R6: After low_volt falls, core_clk_en returns to 1 after exactly D+1 edges. D is the regulator delay when the oscillator was not stopped, and the larger of the regulator and oscillator delays when it was.
- R7: A wake condition present during the gated cycle aborts the entry. low_volt is never raised, and the settling wait uses the regulator delay alone.
- R8: wake_hs is 1 exactly while core_clk_en is 0.
- R9: Writes to address 0 load the regulator delay and writes to address 1 load the oscillator delay, each from the low 12 data bits. Writes to address 3 change nothing.
- R10: In deep sleep, without a wake condition, the block stays asleep. Idle requests have no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 regulator delay, 1 oscillator delay, 2 control |
| cfg_wdata | input | 16 | Register write data; control bit 9 enables oscillator stop |
| idle_req | input | 1 | Idle indication from the clock controller |
| wake_async | input | 1 | Asynchronous wake-up request from interrupt logic |
| clk_req | input | 1 | Synchronous clock request |
| core_clk_en | output | 1 | Enable for the core input clock |
| osc_stop | output | 1 | Stops the crystal oscillator |
| low_volt | output | 1 | Requests reduced voltage from the external regulator |
| wake_hs | output | 1 | Wake-up handshake to the clock controller |

## Verification
The hardest case to reach from the ports is the aborted entry. A wake condition has to be present in the single gated cycle between the idle request and deep sleep. The stimulus raises the clock request in exactly the cycle after the idle request. Randomised rounds pick this abort path at random. They mix it with full sleep cycles that vary the delays, the oscillator option, the hold time and the kind of wake source. The reset-value delays are checked by sleeping before any write. The larger-delay rule is checked with only the control bit written.

// File: rtl/dsleep_pkg.sv
package dsleep_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_GATE   = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_SETTLE = 2'd3
  } pwr_st_e;

  localparam int ADDR_REG_DLY  = 0;
  localparam int ADDR_OSC_DLY  = 1;
  localparam int ADDR_CTL      = 2;
  localparam int OSC_STOP_BIT  = 9;

  // Settling length on exit: the regulator delay, widened to the oscillator
  // delay when the oscillator was actually stopped.
  function automatic logic [31:0] settle_len(input logic [31:0] reg_dly,
                                             input logic [31:0] osc_dly,
                                             input logic        osc_was_off);
    logic [31:0] len;
    len = reg_dly;
    if (osc_was_off && (osc_dly > reg_dly)) len = osc_dly;
    return len;
  endfunction

endpackage

// File: rtl/dsleep_sync.sv
module dsleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dsleep_cfg.sv
module dsleep_cfg
  import dsleep_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 2,
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DLY_W-1:0] reg_dly,
  output logic [DLY_W-1:0] osc_dly,
  output logic             osc_stop_en
);

  localparam logic [AW-1:0] A_REG = AW'(ADDR_REG_DLY);
  localparam logic [AW-1:0] A_OSC = AW'(ADDR_OSC_DLY);
  localparam logic [AW-1:0] A_CTL = AW'(ADDR_CTL);

  logic [DLY_W-1:0] reg_dly_q;
  logic [DLY_W-1:0] osc_dly_q;
  logic             osc_en_q;

  logic wr_reg, wr_osc, wr_ctl;
  assign wr_reg = we && (addr == A_REG);
  assign wr_osc = we && (addr == A_OSC);
  assign wr_ctl = we && (addr == A_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_dly_q <= '1;
      osc_dly_q <= '1;
      osc_en_q  <= 1'b0;
    end else begin
      if (wr_reg) reg_dly_q <= wdata[DLY_W-1:0];
      if (wr_osc) osc_dly_q <= wdata[DLY_W-1:0];
      if (wr_ctl) osc_en_q  <= wdata[OSC_STOP_BIT];
    end
  end

  assign reg_dly     = reg_dly_q;
  assign osc_dly     = osc_dly_q;
  assign osc_stop_en = osc_en_q;

endmodule

// File: rtl/dsleep_fsm.sv
module dsleep_fsm
  import dsleep_pkg::*;
#(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             wake_now,
  input  logic [DLY_W-1:0] reg_dly,
  input  logic [DLY_W-1:0] osc_dly,
  input  logic             osc_stop_en,
  output pwr_st_e          st,
  output logic             ev_gate,
  output logic             ev_abort,
  output logic             ev_exit,
  output logic             settle_done,
  output logic             core_clk_en,
  output logic             osc_stop,
  output logic             low_volt,
  output logic             wake_hs
);

  pwr_st_e          st_q, st_d;
  logic [DLY_W-1:0] cnt_q;
  logic             osc_off_q;
  logic             ev_sleep;

  assign ev_gate     = (st_q == ST_AWAKE) && idle;
  assign ev_sleep    = (st_q == ST_GATE) && !wake_now;
  assign ev_abort    = (st_q == ST_GATE) && wake_now;
  assign ev_exit     = (st_q == ST_SLEEP) && wake_now;
  assign settle_done = (st_q == ST_SETTLE) && (cnt_q == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_AWAKE:  if (ev_gate)     st_d = ST_GATE;
      ST_GATE:   st_d = ev_abort ? ST_SETTLE : ST_SLEEP;
      ST_SLEEP:  if (ev_exit)     st_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) st_d = ST_AWAKE;
      default:   st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_AWAKE;
      cnt_q     <= '0;
      osc_off_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_abort) begin
        cnt_q <= reg_dly;
      end else if (ev_exit) begin
        cnt_q <= DLY_W'(settle_len(32'(reg_dly), 32'(osc_dly), osc_off_q));
      end else if ((st_q == ST_SETTLE) && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (ev_sleep)     osc_off_q <= osc_stop_en;
      else if (ev_exit) osc_off_q <= 1'b0;
    end
  end

  assign st          = st_q;
  assign core_clk_en = (st_q == ST_AWAKE);
  assign wake_hs     = (st_q != ST_AWAKE);
  assign low_volt    = (st_q == ST_SLEEP);
  assign osc_stop    = osc_off_q;

endmodule

// File: rtl/dsleep_seq.sv
module dsleep_seq
  import dsleep_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 2,
  parameter int DLY_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          idle_req,
  input  logic          wake_async,
  input  logic          clk_req,
  output logic          core_clk_en,
  output logic          osc_stop,
  output logic          low_volt,
  output logic          wake_hs
);

  logic [DLY_W-1:0] reg_dly;
  logic [DLY_W-1:0] osc_dly;
  logic             osc_stop_en;
  logic             wake_sync;
  logic             wake_now;
  pwr_st_e          st_q;
  logic             ev_gate, ev_abort, ev_exit, settle_done;

  dsleep_cfg #(.DW(DW), .AW(AW), .DLY_W(DLY_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .reg_dly     (reg_dly),
    .osc_dly     (osc_dly),
    .osc_stop_en (osc_stop_en)
  );

  dsleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (wake_async),
    .q_sync  (wake_sync)
  );

  assign wake_now = wake_sync || clk_req;

  dsleep_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (idle_req),
    .wake_now    (wake_now),
    .reg_dly     (reg_dly),
    .osc_dly     (osc_dly),
    .osc_stop_en (osc_stop_en),
    .st          (st_q),
    .ev_gate     (ev_gate),
    .ev_abort    (ev_abort),
    .ev_exit     (ev_exit),
    .settle_done (settle_done),
    .core_clk_en (core_clk_en),
    .osc_stop    (osc_stop),
    .low_volt    (low_volt),
    .wake_hs     (wake_hs)
  );

endmodule

// File: rtl/dsleep_seq_chk.sv
module dsleep_seq_chk
  import dsleep_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    wake_now,
  input pwr_st_e st,
  input logic    ev_gate,
  input logic    ev_abort,
  input logic    settle_done,
  input logic    core_clk_en,
  input logic    osc_stop,
  input logic    low_volt,
  input logic    wake_hs
);

  a_r2_gate_first: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gate |=> (!core_clk_en && wake_hs && !low_volt));

  a_r3_sleep_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GATE && !wake_now) |=> low_volt);

  a_r4_osc_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> low_volt);

  a_r5_exit_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_volt) |-> $past(wake_now));

  a_r6_clock_back: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |=> core_clk_en);

  a_r7_abort_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!low_volt && !core_clk_en));

  a_r8_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hs == !core_clk_en);

  a_r10_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (low_volt && !wake_now) |=> low_volt);

endmodule

bind dsleep_seq dsleep_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wake_now    (wake_now),
  .st          (st_q),
  .ev_gate     (ev_gate),
  .ev_abort    (ev_abort),
  .settle_done (settle_done),
  .core_clk_en (core_clk_en),
  .osc_stop    (osc_stop),
  .low_volt    (low_volt),
  .wake_hs     (wake_hs)
);

// File: tb/dsleep_seq_test.sv
module dsleep_seq_test;

  localparam int DW = 16;
  localparam int AW = 2;
  localparam int DLY_W = 12;
  localparam int DLY_MAX = (1 << DLY_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic idle_req = 1'b0;
  logic wake_async = 1'b0;
  logic clk_req = 1'b0;
  logic core_clk_en, osc_stop, low_volt, wake_hs;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dsleep_seq #(.DW(DW), .AW(AW), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .idle_req(idle_req), .wake_async(wake_async),
    .clk_req(clk_req), .core_clk_en(core_clk_en), .osc_stop(osc_stop),
    .low_volt(low_volt), .wake_hs(wake_hs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = DW'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  // Expected settling length, restated from the requirements.
  function automatic int exp_wait(input int r, input int o, input bit oen, input bit aborted);
    if (aborted || !oen) return r;
    return (o >= r) ? o : r;
  endfunction

  task automatic sleep_round(input int r, input int o, input bit oen,
                             input bit via_clk, input bit abort, input int hold);
    int d;
    bit early;
    idle_req = 1'b1;
    tick();
    idle_req = 1'b0;
    check(core_clk_en == 1'b0, "R2 clk gated", int'(core_clk_en), 0);
    check(wake_hs == 1'b1, "R2 handshake", int'(wake_hs), 1);
    check(low_volt == 1'b0, "R2 no low-volt yet", int'(low_volt), 0);
    if (abort) begin
      clk_req = 1'b1;
      tick();
      clk_req = 1'b0;
      check(low_volt == 1'b0 && core_clk_en == 1'b0, "R7 abort skips sleep", int'(low_volt), 0);
    end else begin
      tick();
      check(low_volt == 1'b1, "R3 sleep entered", int'(low_volt), 1);
      check(osc_stop == oen, "R4 osc stop option", int'(osc_stop), int'(oen));
      for (int i = 0; i < hold; i++) begin
        idle_req = i[0];
        tick();
        check(low_volt == 1'b1 && core_clk_en == 1'b0, "R10 stays asleep", int'(low_volt), 1);
      end
      idle_req = 1'b0;
      if (via_clk) begin
        clk_req = 1'b1;
        tick();
        clk_req = 1'b0;
        check(low_volt == 1'b0, "R5 clock request exit", int'(low_volt), 0);
        check(osc_stop == 1'b0, "R4 osc released", int'(osc_stop), 0);
      end else begin
        wake_async = 1'b1;
        tick();
        tick();
        check(low_volt == 1'b1, "R5 sync latency", int'(low_volt), 1);
        tick();
        check(low_volt == 1'b0, "R5 async wake exit", int'(low_volt), 0);
        check(osc_stop == 1'b0, "R4 osc released", int'(osc_stop), 0);
        wake_async = 1'b0;
      end
    end
    d = exp_wait(r, o, oen, abort);
    early = 1'b0;
    for (int i = 0; i < d; i++) begin
      tick();
      if (core_clk_en) early = 1'b1;
    end
    check(!early, "R6 clock held off during settle", int'(early), 0);
    tick();
    check(core_clk_en == 1'b1, "R6 clock back after D+1", int'(core_clk_en), 1);
    check(wake_hs == 1'b0, "R8 handshake released", int'(wake_hs), 0);
    repeat (4) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(core_clk_en == 1'b1, "R1 clk enabled", int'(core_clk_en), 1);
    check(low_volt == 1'b0, "R1 low-volt idle", int'(low_volt), 0);
    check(osc_stop == 1'b0, "R1 osc running", int'(osc_stop), 0);
    check(wake_hs == 1'b0, "R1 handshake low", int'(wake_hs), 0);
    tick();
    // R1: regulator delay at its reset maximum
    sleep_round(DLY_MAX, DLY_MAX, 1'b0, 1'b1, 1'b0, 2);
    // R1: oscillator delay at reset maximum dominates a short regulator delay
    wr(0, 3);
    wr(2, 1 << 9);
    sleep_round(3, DLY_MAX, 1'b1, 1'b1, 1'b0, 1);
    // R9: address 3 ignored, addresses 0 and 1 loaded
    wr(0, 5); wr(1, 2); wr(2, 1 << 9);
    wr(3, 30);
    sleep_round(5, 2, 1'b1, 1'b0, 1'b0, 3);
    // Zero delays: clock back on the very next edge
    wr(0, 0); wr(1, 0); wr(2, 0);
    sleep_round(0, 0, 1'b0, 1'b1, 1'b0, 0);
    // R7: directed abort with oscillator option on
    wr(0, 4); wr(1, 9); wr(2, 1 << 9);
    sleep_round(4, 9, 1'b1, 1'b1, 1'b1, 0);
    // Random rounds
    for (int k = 0; k < 24; k++) begin
      int r, o, hold;
      bit oen, via_clk, abort;
      r = $urandom_range(0, 20);
      o = $urandom_range(0, 20);
      oen = 1'($urandom_range(0, 1));
      via_clk = 1'($urandom_range(0, 1));
      abort = ($urandom_range(0, 4) == 0);
      hold = $urandom_range(0, 6);
      wr(0, r); wr(1, o); wr(2, (int'(oen) << 9) | $urandom_range(0, 255));
      sleep_round(r, o, oen, via_clk, abort, hold);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule